// File: doc/BRIEF.md
# Central Bus Arbiter with Request/Grant Lines and Wait-Age Promotion

This block decides which of several masters may drive a shared bus. Every master has a private request wire and a private grant wire. A master raises its request and waits. It may drive the bus only while its grant is high. It keeps the bus for as long as it holds the request, and lowering the request hands the bus back. When the bus is free, the arbiter picks the next owner. Index 0 ranks highest, index N-1 lowest.

Fixed priority alone can lock out low-ranked masters, so each master has a wait-age counter. The counter runs while that master requests but does not own the bus. Once the age reaches the programmable limit `age_limit`, the master is urgent and beats every non-urgent requester. Among several urgent masters, the oldest one wins, and ties go to the lower index.

The control is a two-state machine. In state `ARB_IDLE` all grants are low and the pending requests are arbitrated. In state `ARB_BUSY` exactly one grant, the owner's, is high. There are three transitions:
- `IDLE->BUSY` (take): on a clock edge that sees any request.
- `BUSY->IDLE` (release): on a clock edge that sees the owner's request low.
- `BUSY->BUSY` (hold): on all other edges in `ARB_BUSY`.

Top module: `bus_arbiter`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, every grant is low and every wait-age counter is zero.
- R2: At most one grant bit is high in any cycle.
- R3: A grant goes only to a master whose request was high at the edge that issued it. With all grants low and at least one request high at a clock edge, a grant is high in the next cycle.
- R4: When no requester is urgent, the requester with the lowest index wins (bit i of `req` and `gnt` both belong to master i).
- R5: While the owner keeps its request high, its grant stays high. Requests from any other master, of any rank, do not change it.
- R6: An edge that sees the owner's request low clears all grants for the next cycle. The next grant comes at the earliest one edge after that, so the bus is idle for at least one full cycle between owners.
- R7: When no request is high at an edge, all grants are low in the following cycle.
- R8: A master's wait-age counter:
  - adds one at every edge where the master requests, neither owns the bus nor wins at that edge, and is below the saturation value (all ones);
  - clears when the master's request is low;
  - clears when the master owns the bus or wins.
  A master that drops and re-raises its request therefore loses its accumulated age.
- R9: A requester whose age is at or above `age_limit` is urgent and wins over all non-urgent requesters. Among urgent requesters, the largest age wins, and equal ages go to the lowest index. A limit of 0 makes every requester urgent, which gives oldest-first order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req | input | N | Request line per master, bit i for master i |
| age_limit | input | WAIT_W | Wait age at which a requester becomes urgent |
| gnt | output | N | Grant line per master, at most one high |

## Verification
A stuck or corrupted owner register shows up at `gnt` in the cycle after the take edge. It would be either a grant to a master that is not requesting, or a grant that does not drop one cycle after the owner lets go. A wait-age counter that fails to count or to clear stays invisible until the next arbitration among rival requesters. At that point the wrong master receives the grant in the first cycle after the idle gap. So the bench builds exact edge counts before each contest, and it checks the winner on the very cycle the new grant appears.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_BUSY = 1'b1
    } arb_state_e;
endpackage

// File: rtl/arb_wait_ctr.sv
module arb_wait_ctr #(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pending,
    input  logic              clear,
    output logic [WAIT_W-1:0] age
);
    localparam logic [WAIT_W-1:0] AGE_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            age <= '0;
        end else if (clear) begin
            age <= '0;
        end else if (pending && (age != AGE_MAX)) begin
            age <= age + 1'b1;
        end
    end
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
    parameter int N      = 4,
    parameter int WAIT_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic [N-1:0]             req,
    input  logic [N-1:0][WAIT_W-1:0] ages,
    input  logic [WAIT_W-1:0]        limit,
    output logic                     win_valid,
    output logic [IDX_W-1:0]         win_idx
);
    logic              urg_hit;
    logic [IDX_W-1:0]  urg_idx;
    logic [WAIT_W-1:0] urg_age;
    logic              any_hit;
    logic [IDX_W-1:0]  top_idx;

    always_comb begin
        any_hit = 1'b0;
        top_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any_hit = 1'b1;
                top_idx = IDX_W'(i);
            end
        end

        urg_hit = 1'b0;
        urg_idx = '0;
        urg_age = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (ages[i] >= limit)) begin
                if (!urg_hit || (ages[i] > urg_age)) begin
                    urg_hit = 1'b1;
                    urg_idx = IDX_W'(i);
                    urg_age = ages[i];
                end
            end
        end

        win_valid = any_hit;
        win_idx   = urg_hit ? urg_idx : top_idx;
    end
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
    parameter int N      = 4,
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      req,
    input  logic [WAIT_W-1:0] age_limit,
    output logic [N-1:0]      gnt
);
    import bus_arb_pkg::*;

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    arb_state_e              state_q, state_d;
    logic [IDX_W-1:0]        owner_q, owner_d;
    logic [N-1:0][WAIT_W-1:0] ages;
    logic [N-1:0]            age_clr;
    logic                    win_valid;
    logic [IDX_W-1:0]        win_idx;
    logic                    owner_req;

    assign owner_req = req[owner_q];

    arb_pick #(
        .N      (N),
        .WAIT_W (WAIT_W),
        .IDX_W  (IDX_W)
    ) u_pick (
        .req       (req),
        .ages      (ages),
        .limit     (age_limit),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    always_comb begin
        for (int i = 0; i < N; i++) begin
            age_clr[i] = !req[i]
                       || ((state_q == ARB_BUSY) && (owner_q == IDX_W'(i)))
                       || ((state_q == ARB_IDLE) && win_valid && (win_idx == IDX_W'(i)));
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_age
        arb_wait_ctr #(
            .WAIT_W (WAIT_W)
        ) u_ctr (
            .clk     (clk),
            .rst     (rst),
            .pending (req[g]),
            .clear   (age_clr[g]),
            .age     (ages[g])
        );
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (win_valid) begin
                    state_d = ARB_BUSY;
                    owner_d = win_idx;
                end
            end
            ARB_BUSY: begin
                if (!owner_req) begin
                    state_d = ARB_IDLE;
                end
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARB_IDLE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    // outputs
    always_comb begin
        gnt = '0;
        if (state_q == ARB_BUSY) begin
            gnt[owner_q] = 1'b1;
        end
    end
endmodule

// File: rtl/bus_arbiter_chk.sv
module bus_arbiter_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] req,
    input logic [N-1:0] gnt
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (gnt == '0));

    // R2
    one_grant_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));

    // R3
    grant_to_requester_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt == '0) |=> ((gnt & ~$past(req)) == '0));

    // R3
    idle_take_chk: assert property (@(posedge clk) disable iff (rst)
        ((gnt == '0) && (req != '0)) |=> (gnt != '0));

    // R5
    hold_owner_chk: assert property (@(posedge clk) disable iff (rst)
        ((gnt & req) != '0) |=> (gnt == $past(gnt)));

    // R6
    release_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ((gnt != '0) && ((gnt & req) == '0)) |=> (gnt == '0));

    // R7
    no_request_chk: assert property (@(posedge clk) disable iff (rst)
        (req == '0) |=> (gnt == '0));
endmodule

bind bus_arbiter bus_arbiter_chk #(.N(N)) u_arb_chk (
    .clk (clk),
    .rst (rst),
    .req (req),
    .gnt (gnt)
);

// File: tb/test_bus_arbiter.sv
`timescale 1ns/1ps
module test_bus_arbiter;
    localparam int N      = 4;
    localparam int WAIT_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N-1:0]      req = '0;
    logic [WAIT_W-1:0] age_limit = 8'd255;
    logic [N-1:0]      gnt;

    int checks   = 0;
    int failures = 0;
    bit multi_seen = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bus_arbiter #(.N(N), .WAIT_W(WAIT_W)) i_bus_arbiter (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .age_limit (age_limit),
        .gnt       (gnt)
    );

    // {req, expected grant}: priority when nobody is urgent (R4, R3)
    localparam int NV = 9;
    localparam logic [7:0] VEC [NV] = '{
        {4'b0001, 4'b0001}, {4'b0010, 4'b0010}, {4'b1100, 4'b0100},
        {4'b1010, 4'b0010}, {4'b1111, 4'b0001}, {4'b1000, 4'b1000},
        {4'b0110, 4'b0010}, {4'b1110, 4'b0010}, {4'b0101, 4'b0001}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string rid, input logic [N-1:0] exp);
        checks++;
        if (gnt !== exp) begin
            failures++;
            $display("FAIL %s gnt=%b expected=%b", rid, gnt, exp);
        end
    endtask

    task automatic go_idle();
        req = '0;
        tick();
        tick();
    endtask

    always @(negedge clk) begin
        if (!rst && ($countones(gnt) > 1)) multi_seen = 1'b1;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        req = 4'b1111;
        tick();
        tick();
        check("R1 during reset", 4'b0000);
        rst = 1'b0;
        req = '0;
        tick();
        check("R1 after reset", 4'b0000);

        for (int v = 0; v < NV; v++) begin
            go_idle();
            req = VEC[v][7:4];
            tick();
            check("R4 priority vector", VEC[v][3:0]);
        end

        // R5 hold, R6 release gap, R7 no request
        go_idle();
        req = 4'b0100;
        tick();
        check("R5 take", 4'b0100);
        req = 4'b0101;
        for (int k = 0; k < 3; k++) begin
            tick();
            check("R5 hold vs higher", 4'b0100);
        end
        req = 4'b0001;
        tick();
        check("R6 gap after release", 4'b0000);
        tick();
        check("R6 next owner", 4'b0001);
        req = 4'b0000;
        tick();
        check("R7 released", 4'b0000);
        tick();
        check("R7 stays idle", 4'b0000);

        // R9 promotion of an old low-priority requester
        age_limit = 8'd4;
        go_idle();
        req = 4'b1001;
        tick();
        check("R9 first owner", 4'b0001);
        repeat (6) tick();
        req = 4'b1000;
        tick();
        check("R6 gap", 4'b0000);
        req = 4'b1001;
        tick();
        check("R9 urgent wins", 4'b1000);

        // R8 dropping a request clears the age
        go_idle();
        req = 4'b1001;
        tick();
        repeat (6) tick();
        req = 4'b0001;
        tick();
        req = 4'b1001;
        tick();
        req = 4'b1000;
        tick();
        req = 4'b1001;
        tick();
        check("R8 age cleared by drop", 4'b0001);

        // R9 equal ages: lowest index among urgent
        age_limit = 8'd2;
        go_idle();
        req = 4'b0001;
        tick();
        req = 4'b1111;
        repeat (4) tick();
        req = 4'b1110;
        tick();
        check("R6 gap tie", 4'b0000);
        tick();
        check("R9 tie lowest index", 4'b0010);

        // R9 largest age wins among urgent
        go_idle();
        req = 4'b0001;
        tick();
        req = 4'b1001;
        repeat (2) tick();
        req = 4'b1011;
        repeat (3) tick();
        req = 4'b1010;
        tick();
        tick();
        check("R9 oldest urgent", 4'b1000);

        // R1 reset while owned
        rst = 1'b1;
        tick();
        check("R1 reset while owned", 4'b0000);
        rst = 1'b0;
        req = '0;
        tick();

        checks++;
        if (multi_seen) begin
            failures++;
            $display("FAIL R2 more than one grant seen actual=1 expected=0");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule